// File: doc/BRIEF.md
# Machine Status Word and Coprocessor Instruction Gate

This block keeps the four-bit machine status word of a processor core and, for every instruction the decoder presents, decides whether an instruction aimed at the floating-point coprocessor may go ahead, must wait, or must trap. Software loads the word through a write port and reads it back through a read port. The lowest bit switches the core into protected mode. Once set, software cannot clear it; only a reset can.

Each cycle the decoder presents one instruction class: a coprocessor wait, a coprocessor (escape) operation, or anything else. The gate combines that class with the status bits and with the coprocessor's active-low busy and error lines. When a trap applies, the gate issues a one-cycle exception pulse with an 8-bit vector on the cycle after the instruction. When the coprocessor is busy and no trap applies, it raises a stall in the same cycle. The issuer holds the instruction while the stall is high.

Top module: `mstat_fpu_gate`

## Requirements
- R1: While reset is asserted, and afterwards until the first load, the status word reads 0000, and prot_mode, exc_valid and stall are all 0.
- R2: Status-word bit positions are bit0 = protect, bit1 = monitor-wait, bit2 = emulate, bit3 = task-switched. A load writes bits 3..1 with the supplied value, and the new word is visible on msw_rd_data in the cycle after the load.
- R3: A load sets bit0 to the OR of its current value and the written bit, so software cannot clear it. prot_mode always equals bit0, and only reset returns it to 0.
- R4: insn_class encoding: 00 other, 01 wait, 10 coprocessor operation, 11 treated as other. A wait instruction while bit1 is set raises an exception with vector 7.
- R5: A coprocessor operation while bit2 is set raises an exception with vector 7.
- R6: A coprocessor operation while bit3 is set raises an exception with vector 7.
- R7: A wait or coprocessor operation with cop_error_n low raises vector 16, unless one of the vector-7 conditions of R4 to R6 applies; in that case vector 7 wins.
- R8: A wait or coprocessor operation with cop_busy_n low and no trap condition drives stall high in the same cycle and raises no exception. A trap condition overrides busy, so there is no stall.
- R9: Instructions of class other (00 or 11) never raise an exception or a stall, whatever the status word, busy or error.
- R10: A wait instruction ignores bit2 and bit3. With bit1 clear and the coprocessor idle and error-free, it proceeds with no exception.
- R11: exc_valid is high only in the cycle directly after an instruction cycle that met a trap condition. Back-to-back trapping instructions give back-to-back pulses, and it drops as soon as trapping stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msw_wr_en | input | 1 | Load status word this cycle |
| msw_wr_data | input | 4 | Value for the load |
| msw_rd_data | output | 4 | Current status word |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_class | input | 2 | Instruction class (00 other, 01 wait, 10 coprocessor op, 11 other) |
| cop_busy_n | input | 1 | Coprocessor busy, active low |
| cop_error_n | input | 1 | Coprocessor error, active low |
| exc_valid | output | 1 | One-cycle exception request |
| exc_vector | output | 8 | Exception vector, meaningful while exc_valid is high |
| stall | output | 1 | Hold the presented instruction |
| prot_mode | output | 1 | Protected mode is active |

## Verification
The bench attacks the sticky protect bit by writing zero after setting it; a design that copied bit0 straight from the data would drop prot_mode. It stacks conditions on one instruction (emulate with error, task-switched with busy) to expose a wrong priority order, which would show up as vector 16 in place of 7 or as a stall in place of a trap. It presents wait instructions with emulate and task-switched set but monitor-wait clear, and presents class-other instructions under every hazard. A design that decoded classes loosely would trap or stall there. Back-to-back trapping instructions followed by an idle cycle check that the pulse neither stretches nor gets lost.

// File: rtl/mgate_pkg.sv
package mgate_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_WAIT  = 2'b01,
    CLS_ESC   = 2'b10,
    CLS_RSVD  = 2'b11
  } insn_cls_e;

  localparam int unsigned MSW_W  = 4;
  localparam int unsigned BIT_PE = 0;
  localparam int unsigned BIT_MP = 1;
  localparam int unsigned BIT_EM = 2;
  localparam int unsigned BIT_TS = 3;

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } msw_t;

endpackage

// File: rtl/mgate_rst_sync.sv
module mgate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mgate_msw_reg.sv
module mgate_msw_reg
  import mgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MSW_W-1:0] wr_data,
  output msw_t             msw_q
);

  msw_t msw_d;

  // protect bit accumulates; the other three take the written value
  always_comb begin
    msw_d    = msw_q;
    msw_d.pe = msw_q.pe | wr_data[BIT_PE];
    msw_d.mp = wr_data[BIT_MP];
    msw_d.em = wr_data[BIT_EM];
    msw_d.ts = wr_data[BIT_TS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     msw_q <= '0;
    else if (wr_en) msw_q <= msw_d;
  end

endmodule

// File: rtl/mgate_decide.sv
module mgate_decide
  import mgate_pkg::*;
#(
  parameter int unsigned       VEC_W   = 8,
  parameter logic [VEC_W-1:0]  NP_VEC  = VEC_W'(7),
  parameter logic [VEC_W-1:0]  ERR_VEC = VEC_W'(16)
) (
  input  msw_t             msw,
  input  logic             valid,
  input  logic [1:0]       cls,
  input  logic             busy_n,
  input  logic             error_n,
  output logic             trap,
  output logic [VEC_W-1:0] trap_vec,
  output logic             stall
);

  insn_cls_e cls_e;
  logic      is_wait;
  logic      is_esc;

  always_comb begin
    cls_e   = insn_cls_e'(cls);
    is_wait = valid && (cls_e == CLS_WAIT);
    is_esc  = valid && (cls_e == CLS_ESC);
  end

  // priority: emulate, task-switched (and monitor-wait for WAIT), error, busy
  always_comb begin
    trap     = 1'b0;
    trap_vec = NP_VEC;
    stall    = 1'b0;
    if (is_esc && msw.em) begin
      trap = 1'b1;
    end else if (is_esc && msw.ts) begin
      trap = 1'b1;
    end else if (is_wait && msw.mp) begin
      trap = 1'b1;
    end else if ((is_wait || is_esc) && !error_n) begin
      trap     = 1'b1;
      trap_vec = ERR_VEC;
    end else if ((is_wait || is_esc) && !busy_n) begin
      stall = 1'b1;
    end
  end

endmodule

// File: rtl/mgate_exc_reg.sv
module mgate_exc_reg #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap,
  input  logic [VEC_W-1:0] trap_vec,
  output logic             exc_valid,
  output logic [VEC_W-1:0] exc_vector
);

  logic             valid_d;
  logic             vec_en;

  always_comb begin
    valid_d = trap;
    vec_en  = trap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_valid <= 1'b0;
    else        exc_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exc_vector <= '0;
    else if (vec_en) exc_vector <= trap_vec;
  end

endmodule

// File: rtl/mstat_fpu_gate.sv
module mstat_fpu_gate
  import mgate_pkg::*;
#(
  parameter int unsigned      VEC_W   = 8,
  parameter logic [VEC_W-1:0] NP_VEC  = VEC_W'(7),
  parameter logic [VEC_W-1:0] ERR_VEC = VEC_W'(16),
  parameter int unsigned      RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msw_wr_en,
  input  logic [3:0]       msw_wr_data,
  output logic [3:0]       msw_rd_data,
  input  logic             insn_valid,
  input  logic [1:0]       insn_class,
  input  logic             cop_busy_n,
  input  logic             cop_error_n,
  output logic             exc_valid,
  output logic [VEC_W-1:0] exc_vector,
  output logic             stall,
  output logic             prot_mode
);

  logic             rst_sync_n;
  msw_t             msw_q;
  logic             trap;
  logic [VEC_W-1:0] trap_vec;
  logic             stall_raw;

  mgate_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mgate_msw_reg u_msw (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (msw_wr_en),
    .wr_data (msw_wr_data),
    .msw_q   (msw_q)
  );

  mgate_decide #(.VEC_W(VEC_W), .NP_VEC(NP_VEC), .ERR_VEC(ERR_VEC)) u_decide (
    .msw      (msw_q),
    .valid    (insn_valid),
    .cls      (insn_class),
    .busy_n   (cop_busy_n),
    .error_n  (cop_error_n),
    .trap     (trap),
    .trap_vec (trap_vec),
    .stall    (stall_raw)
  );

  mgate_exc_reg #(.VEC_W(VEC_W)) u_exc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trap       (trap),
    .trap_vec   (trap_vec),
    .exc_valid  (exc_valid),
    .exc_vector (exc_vector)
  );

  assign msw_rd_data = msw_q;
  assign prot_mode   = msw_q.pe;
  assign stall       = stall_raw & rst_sync_n;

endmodule

// File: rtl/mgate_chk.sv
module mgate_chk #(
  parameter int unsigned      VEC_W   = 8,
  parameter logic [VEC_W-1:0] NP_VEC  = VEC_W'(7),
  parameter logic [VEC_W-1:0] ERR_VEC = VEC_W'(16)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msw_wr_en,
  input logic [3:0]       msw_wr_data,
  input logic [3:0]       msw_rd_data,
  input logic             insn_valid,
  input logic [1:0]       insn_class,
  input logic             cop_busy_n,
  input logic             cop_error_n,
  input logic             exc_valid,
  input logic [VEC_W-1:0] exc_vector,
  input logic             stall,
  input logic             prot_mode
);

  a_r2_load_bits: assert property (@(posedge clk) disable iff (!rst_n)
    msw_wr_en |=> msw_rd_data[3:1] == $past(msw_wr_data[3:1]));

  a_r3_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prot_mode) |-> prot_mode);

  a_r3_pe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    prot_mode == msw_rd_data[0]);

  a_r4_wait_mp: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_class == 2'b01 && msw_rd_data[1])
      |=> (exc_valid && exc_vector == NP_VEC));

  a_r5_esc_em: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_class == 2'b10 && msw_rd_data[2])
      |=> (exc_valid && exc_vector == NP_VEC));

  a_r6_esc_ts: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_class == 2'b10 && msw_rd_data[3])
      |=> (exc_valid && exc_vector == NP_VEC));

  a_r7_error: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_class == 2'b10 && msw_rd_data[3:2] == 2'b00 && !cop_error_n)
      |=> (exc_valid && exc_vector == ERR_VEC));

  a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (insn_valid && !cop_busy_n && cop_error_n &&
               (insn_class == 2'b01 || insn_class == 2'b10)));

  a_r8_stall_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !exc_valid);

  a_r9_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_class[0] == insn_class[1]) |=> !exc_valid);

  a_r11_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_vector == NP_VEC || exc_vector == ERR_VEC));

  a_r11_needs_insn: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(insn_valid));

endmodule

bind mstat_fpu_gate mgate_chk #(.VEC_W(VEC_W), .NP_VEC(NP_VEC), .ERR_VEC(ERR_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .msw_wr_en   (msw_wr_en),
  .msw_wr_data (msw_wr_data),
  .msw_rd_data (msw_rd_data),
  .insn_valid  (insn_valid),
  .insn_class  (insn_class),
  .cop_busy_n  (cop_busy_n),
  .cop_error_n (cop_error_n),
  .exc_valid   (exc_valid),
  .exc_vector  (exc_vector),
  .stall       (stall),
  .prot_mode   (prot_mode)
);

// File: tb/mstat_fpu_gate_bench.sv
module mstat_fpu_gate_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msw_wr_en;
  logic [3:0] msw_wr_data;
  logic [3:0] msw_rd_data;
  logic       insn_valid;
  logic [1:0] insn_class;
  logic       cop_busy_n;
  logic       cop_error_n;
  logic       exc_valid;
  logic [7:0] exc_vector;
  logic       stall;
  logic       prot_mode;

  int checks   = 0;
  int failures = 0;

  // reference state
  logic [3:0] m_msw;
  logic       m_exc;
  int         m_vec;
  string      prev_tag;

  always #10 clk = ~clk;

  mstat_fpu_gate u_mstat_fpu_gate (
    .clk(clk), .rst_n(rst_n),
    .msw_wr_en(msw_wr_en), .msw_wr_data(msw_wr_data), .msw_rd_data(msw_rd_data),
    .insn_valid(insn_valid), .insn_class(insn_class),
    .cop_busy_n(cop_busy_n), .cop_error_n(cop_error_n),
    .exc_valid(exc_valid), .exc_vector(exc_vector),
    .stall(stall), .prot_mode(prot_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one clock of stimulus; registered outputs are compared against the
  // prior cycle's prediction, stall against this cycle's
  task automatic step(input logic we, input logic [3:0] wd, input logic v,
                      input logic [1:0] c, input logic bn, input logic en,
                      input string tag);
    logic trap, stl, isw, ise;
    int   vec;
    @(negedge clk);
    msw_wr_en = we; msw_wr_data = wd; insn_valid = v; insn_class = c;
    cop_busy_n = bn; cop_error_n = en;
    #5;
    isw = v && (c == 2'b01);
    ise = v && (c == 2'b10);
    trap = 1'b0; stl = 1'b0; vec = 0;
    if (ise && (m_msw[2] || m_msw[3]))      begin trap = 1'b1; vec = 7;  end
    else if (isw && m_msw[1])               begin trap = 1'b1; vec = 7;  end
    else if ((isw || ise) && !en)           begin trap = 1'b1; vec = 16; end
    else if ((isw || ise) && !bn)           stl = 1'b1;
    chk(prev_tag, "msw_rd_data", msw_rd_data, m_msw);
    chk(prev_tag, "prot_mode", prot_mode, m_msw[0]);
    chk(prev_tag, "exc_valid", exc_valid, m_exc);
    if (m_exc) chk(prev_tag, "exc_vector", exc_vector, m_vec);
    chk(tag, "stall", stall, stl);
    @(posedge clk);
    m_exc = trap;
    m_vec = vec;
    if (we) m_msw = {wd[3:1], m_msw[0] | wd[0]};
    prev_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 4'h0, 1'b0, 2'b00, 1'b1, 1'b1, tag);
  endtask

  task automatic wr(input logic [3:0] wd, input string tag);
    step(1'b1, wd, 1'b0, 2'b00, 1'b1, 1'b1, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    msw_wr_en = 1'b0; msw_wr_data = 4'h0; insn_valid = 1'b0; insn_class = 2'b00;
    cop_busy_n = 1'b1; cop_error_n = 1'b1;
    #5;
    m_msw = 4'h0; m_exc = 1'b0; m_vec = 0;
    chk(tag, "reset msw_rd_data", msw_rd_data, 0);
    chk(tag, "reset prot_mode", prot_mode, 0);
    chk(tag, "reset exc_valid", exc_valid, 0);
    chk(tag, "reset stall", stall, 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_tag = tag;
    for (int i = 0; i < 3; i++) idle(tag);
  endtask

  initial begin
    #(20 * 5000);
    failures++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    prev_tag = "R1";
    do_reset("R1");

    // R2: plain load of the upper bits
    wr(4'b1110, "R2"); idle("R2");
    wr(4'b0000, "R2"); idle("R2");

    // R3: protect bit sticks
    wr(4'b0001, "R3"); idle("R3");
    wr(4'b0000, "R3"); idle("R3");
    wr(4'b1010, "R3"); idle("R3");

    // R4: wait with monitor-wait
    wr(4'b0010, "R4");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b1, 1'b1, "R4"); idle("R4");

    // R10: wait ignores emulate and task-switched
    wr(4'b1100, "R10");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b1, 1'b1, "R10"); idle("R10");

    // R5 / R6
    wr(4'b0100, "R5");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b1, "R5"); idle("R5");
    wr(4'b1000, "R6");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b1, "R6"); idle("R6");

    // R7: error vector and its precedence
    wr(4'b0000, "R7");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b0, "R7"); idle("R7");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b1, 1'b0, "R7"); idle("R7");
    wr(4'b0100, "R7");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b0, "R7"); idle("R7");
    wr(4'b0010, "R7");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b0, 1'b0, "R7"); idle("R7");

    // R8: busy stalls; trap beats busy
    wr(4'b0000, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 1'b1, 2'b10, 1'b0, 1'b1, "R8");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b1, "R8");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b0, 1'b1, "R8");
    step(1'b0, 4'h0, 1'b1, 2'b01, 1'b1, 1'b1, "R8");
    wr(4'b1000, "R8");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b0, 1'b1, "R8"); idle("R8");

    // R9: class other under every hazard
    wr(4'b1110, "R9");
    step(1'b0, 4'h0, 1'b1, 2'b00, 1'b0, 1'b0, "R9");
    step(1'b0, 4'h0, 1'b1, 2'b11, 1'b0, 1'b0, "R9"); idle("R9");

    // R11: back-to-back pulses, then drop
    wr(4'b0100, "R11");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b1, "R11");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b1, "R11");
    wr(4'b0000, "R11");
    step(1'b0, 4'h0, 1'b1, 2'b10, 1'b1, 1'b0, "R11");
    idle("R11"); idle("R11");

    // R3: only reset clears protect
    do_reset("R1");
    chk("R3", "prot_mode after reset", prot_mode, 0);
    idle("R3");

    summary();
    $finish;
  end

endmodule